// File: doc/BRIEF.md
# Dynamic Memory Array with Refresh Sequencer

This block pairs a behavioural dynamic memory array with the sequencer that keeps it alive. A host opens a row by placing the row number on the shared address pins and pulsing `row_stb`. It then places the column number on the same pins and pulses `col_stb`, together with the write flag and write data. Opening a row copies it into a row buffer and wipes it in the array, because sensing is destructive. The column access works on the buffer. The buffer is then written back, and a precharge interval follows before the next activation.

An interval timer raises a refresh request every `REF_INT` cycles. Each refresh opens the row selected by a wrapping row pointer and writes it straight back. Every row carries an age counter that a writeback clears. A row touched once its age has passed `RETAIN` yields all-zero data and sets a sticky error flag, so lost refreshes show up as data loss.

The row command is a valid/ready handshake: `row_stb` is taken only in a cycle where `ready` is high, and it is ignored otherwise. The column strobe is taken only while a host row is open. Read data carries no back-pressure and appears for one cycle on `rdata` with `rvalid`.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: A row command taken while `ready` is high opens that row. The next `col_stb` selects a column from `addr` bits [COL_W-1:0]. For a read (`we`=0), the stored word appears on `rdata` with `rvalid` high in the cycle after `col_stb`.
- R2: A write (`we`=1) replaces only the addressed word of the row. The other columns of that row keep their values.
- R3: Reading a location does not lose it. Repeated reads return the same value, because every activation is followed by a writeback.
- R4: After a column access, `ready` stays low for the writeback cycle and for `PRE_CYC` further precharge cycles.
- R5: A refresh request is raised every `REF_INT` cycles. While one is pending, `ready` is low, so refresh wins over a new host row command.
- R6: A refresh does not break into an open host row. A host row held open for longer than `RETAIN` cycles still completes with correct data.
- R7: The refresh row pointer steps by one per refresh and wraps from row ROWS-1 to row 0. With no host traffic, all stored data is kept indefinitely.
- R8: A row touched (by the host or by refresh) after more than `RETAIN` cycles without a writeback returns all zeros, and it is written back as zeros.
- R9: `err` rises when a stale row is touched and stays high until reset.
- R10: After reset, `ready` is high, `rvalid` and `err` are low, and every word reads as zero.
- R11: A write access never produces `rvalid`.
- R12: A `col_stb` given while no host row is open is ignored and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb | input | 1 | Row command valid; row number on `addr` |
| col_stb | input | 1 | Column strobe; column number on `addr` |
| addr | input | AW | Shared row/column address pins |
| we | input | 1 | Write flag, sampled with `col_stb` |
| wdata | input | DW | Write data, sampled with `col_stb` |
| ready | output | 1 | Row command can be taken this cycle |
| rdata | output | DW | Read data |
| rvalid | output | 1 | `rdata` holds a read result for this cycle |
| err | output | 1 | Sticky flag: a stale row was touched |

## Verification
The bench uses the default build: 8 rows of 4 eight-bit words, a refresh every 16 cycles, a retention limit of 200 cycles and 2 precharge cycles. A full refresh sweep takes 128 cycles, so several thousand cycles of mixed random traffic pass through many pointer wraps well inside the retention limit. Holding one host row open for 300 cycles starves refresh long enough for every other row to decay, which brings the zero-data and sticky-error paths within reach.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_WB,
    ST_PRE
  } dram_st_t;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int ROWS    = 8,
  parameter int REF_INT = 16,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TW     = (REF_INT > 1) ? $clog2(REF_INT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serve,
  input  logic             adv,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  logic [TW-1:0] tick_cnt;
  logic          tick;

  assign tick = (tick_cnt == TW'(REF_INT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      pend     <= 1'b0;
      row      <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      pend     <= (pend & ~serve) | tick;
      if (adv) row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
    end
  end
endmodule

// File: rtl/dram_cells.sv
module dram_cells #(
  parameter int ROWS   = 8,
  parameter int COLS   = 4,
  parameter int DW     = 8,
  parameter int RETAIN = 200,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int LW    = COLS * DW,
  localparam int AGW   = $clog2(RETAIN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic [ROW_W-1:0] act_row,
  input  logic             wb,
  input  logic [ROW_W-1:0] wb_row,
  input  logic [LW-1:0]    wb_data,
  output logic [LW-1:0]    rd_data,
  output logic             stale
);
  logic [LW-1:0]  mem [ROWS];
  logic [AGW-1:0] age [ROWS];

  // Sensing a decayed row yields nothing useful.
  assign stale   = age[act_row] > AGW'(RETAIN);
  assign rd_data = stale ? '0 : mem[act_row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        mem[r] <= '0;
        age[r] <= '0;
      end
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (wb && wb_row == ROW_W'(r)) begin
          mem[r] <= wb_data;
          age[r] <= '0;
        end else begin
          if (act && act_row == ROW_W'(r)) mem[r] <= '0;  // destructive sense
          if (age[r] != AGW'(RETAIN + 1)) age[r] <= age[r] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int COLS    = 4,
  parameter int DW      = 8,
  parameter int PRE_CYC = 2,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int LW     = COLS * DW,
  localparam int PCW    = $clog2(PRE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_stb,
  input  logic             col_stb,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  input  logic             pend,
  input  logic [ROW_W-1:0] ref_row,
  input  logic [LW-1:0]    rd_data,
  input  logic             stale,
  output logic             act,
  output logic [ROW_W-1:0] act_row,
  output logic             wb,
  output logic [ROW_W-1:0] wb_row,
  output logic [LW-1:0]    wb_data,
  output logic             serve,
  output logic             adv,
  output logic             ready,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             err
);
  dram_st_t         st;
  logic [ROW_W-1:0] hrow;
  logic             rsel;
  logic [LW-1:0]    rbuf;
  logic [PCW-1:0]   pcnt;
  logic [COL_W-1:0] col;

  assign col     = addr[COL_W-1:0];
  assign ready   = (st == ST_IDLE) && !pend;
  assign serve   = (st == ST_IDLE) && pend;
  assign act     = (st == ST_IDLE) && (pend || row_stb);
  assign act_row = pend ? ref_row : addr[ROW_W-1:0];
  assign wb      = (st == ST_WB);
  assign wb_row  = rsel ? ref_row : hrow;
  assign wb_data = rbuf;
  assign adv     = wb && rsel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      hrow   <= '0;
      rsel   <= 1'b0;
      rbuf   <= '0;
      pcnt   <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (st)
        ST_IDLE: if (act) begin
          rbuf <= rd_data;
          rsel <= pend;
          hrow <= addr[ROW_W-1:0];
          st   <= pend ? ST_WB : ST_OPEN;
          if (stale) err <= 1'b1;
        end
        ST_OPEN: if (col_stb) begin
          if (we) begin
            rbuf[int'(col)*DW +: DW] <= wdata;
          end else begin
            rdata  <= rbuf[int'(col)*DW +: DW];
            rvalid <= 1'b1;
          end
          st <= ST_WB;
        end
        ST_WB: begin
          st   <= ST_PRE;
          pcnt <= PCW'(PRE_CYC - 1);
        end
        default: begin
          if (pcnt == '0) st <= ST_IDLE;
          else            pcnt <= pcnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROWS    = 8,
  parameter int COLS    = 4,
  parameter int DW      = 8,
  parameter int REF_INT = 16,
  parameter int RETAIN  = 200,
  parameter int PRE_CYC = 2,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_stb,
  input  logic          col_stb,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          err
);
  localparam int LW = COLS * DW;

  logic             ref_pend, ref_serve, ref_adv;
  logic [ROW_W-1:0] ref_row;
  logic             act, wb, stale;
  logic [ROW_W-1:0] act_row, wb_row;
  logic [LW-1:0]    wb_data, rd_data;

  dram_ref_timer #(.ROWS(ROWS), .REF_INT(REF_INT)) timer_i (
    .clk(clk), .rst_n(rst_n), .serve(ref_serve), .adv(ref_adv),
    .pend(ref_pend), .row(ref_row)
  );

  dram_cells #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .RETAIN(RETAIN)) cells_i (
    .clk(clk), .rst_n(rst_n), .act(act), .act_row(act_row),
    .wb(wb), .wb_row(wb_row), .wb_data(wb_data),
    .rd_data(rd_data), .stale(stale)
  );

  dram_seq #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .PRE_CYC(PRE_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb),
    .addr(addr), .we(we), .wdata(wdata), .pend(ref_pend), .ref_row(ref_row),
    .rd_data(rd_data), .stale(stale), .act(act), .act_row(act_row),
    .wb(wb), .wb_row(wb_row), .wb_data(wb_data), .serve(ref_serve),
    .adv(ref_adv), .ready(ready), .rdata(rdata), .rvalid(rvalid), .err(err)
  );
endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int ROWS   = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             col_stb,
  input logic             we,
  input logic             rvalid,
  input logic             err,
  input logic             pend,
  input logic [ROW_W-1:0] ref_row
);
  AST_RVALID_AFTER_COL: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(col_stb));  // R1
  AST_RVALID_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !$past(we));  // R11
  AST_BUSY_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !ready);  // R4
  AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !ready);  // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);  // R9
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_row) |-> ref_row == (($past(ref_row) == ROW_W'(ROWS - 1)) ? '0 : $past(ref_row) + 1'b1));  // R7
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.ROWS(ROWS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .col_stb(col_stb), .we(we),
  .rvalid(rvalid), .err(err), .pend(ref_pend), .ref_row(ref_row)
);

// File: tb/dram_refresh_ctrl_tb_top.sv
module dram_refresh_ctrl_tb_top;
  localparam int ROWS = 8, COLS = 4, DW = 8, REF_INT = 16, RETAIN = 200, PRE_CYC = 2;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          row_stb = 1'b0, col_stb = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, rvalid, err;
  logic [DW-1:0] rdata;

  int tests = 0, fails = 0;
  logic [DW-1:0] model [ROWS][COLS];

  always #2 clk = ~clk;

  dram_refresh_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .REF_INT(REF_INT),
    .RETAIN(RETAIN), .PRE_CYC(PRE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb), .addr(addr),
    .we(we), .wdata(wdata), .ready(ready), .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  function automatic logic [DW-1:0] exp_word(int r, int c);
    return model[r][c];
  endfunction

  task automatic check(string req, logic [31:0] act_v, logic [31:0] exp_v);
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  // Ends on the negedge where the read result is visible.
  task automatic host_op(int r, int c, bit w, logic [DW-1:0] d, int hold,
                         output logic [DW-1:0] rd, output logic rv);
    wait_ready();
    row_stb = 1'b1; addr = AW'(r);
    @(negedge clk);
    row_stb = 1'b0;
    repeat (hold) @(negedge clk);
    col_stb = 1'b1; addr = AW'(c); we = w; wdata = d;
    @(negedge clk);
    col_stb = 1'b0; we = 1'b0;
    rd = rdata; rv = rvalid;
    if (w) model[r][c] = d;
  endtask

  task automatic do_read(int r, int c, string req);
    logic [DW-1:0] rd; logic rv;
    host_op(r, c, 1'b0, '0, 0, rd, rv);
    check({req, " rvalid"}, 32'(rv), 32'd1);
    check(req, 32'(rd), 32'(exp_word(r, c)));
  endtask

  task automatic do_write(int r, int c, logic [DW-1:0] d);
    logic [DW-1:0] rd; logic rv;
    host_op(r, c, 1'b1, d, 0, rd, rv);
    check("R11 no rvalid on write", 32'(rv), 32'd0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) model[r][c] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", 32'(ready), 32'd1);
    check("R10 rvalid after reset", 32'(rvalid), 32'd0);
    check("R10 err after reset", 32'(err), 32'd0);
    do_read(5, 2, "R10 zero after reset");

    // R2: a write touches only its own column
    do_write(2, 1, 8'hA5);
    do_read(2, 0, "R2 neighbour kept");
    do_read(2, 1, "R2 written word");
    // R3: repeated reads keep the word
    do_read(2, 1, "R3 reread");
    do_read(2, 1, "R3 reread again");

    // R4: busy through writeback and precharge
    begin
      int lows;
      do_read(2, 1, "R1 read before precharge");
      lows = 0;
      while (!ready) begin lows++; @(negedge clk); end
      tests++;
      if (lows < PRE_CYC + 1) begin
        fails++;
        $display("FAIL R4: actual %0d busy cycles expected >= %0d", lows, PRE_CYC + 1);
      end
    end

    // R12: column strobe with no open row is ignored
    wait_ready();
    col_stb = 1'b1; we = 1'b1; addr = AW'(1); wdata = 8'h3C;
    @(negedge clk);
    col_stb = 1'b0; we = 1'b0;
    check("R12 no rvalid", 32'(rvalid), 32'd0);
    do_read(2, 1, "R12 word unchanged");

    // R5: refresh requests every REF_INT cycles while idle
    begin
      int falls; logic prev;
      falls = 0; prev = ready;
      for (int i = 0; i < 10 * REF_INT; i++) begin
        @(negedge clk);
        if (prev && !ready) falls++;
        prev = ready;
      end
      tests++;
      if (falls < 9 || falls > 11) begin
        fails++;
        $display("FAIL R5: actual %0d refreshes expected about 10", falls);
      end
    end

    // fill every word with a nonzero pattern
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) do_write(r, c, DW'(8'h11 * (c + 1) + r) | 8'h80);

    // random traffic with idle gaps, checked against the model
    for (int i = 0; i < 300; i++) begin
      int r, c;
      r = int'($urandom % ROWS); c = int'($urandom % COLS);
      if ($urandom % 2) do_write(r, c, DW'($urandom));
      else do_read(r, c, "R1 R3 random read");
      repeat ($urandom % 40) @(negedge clk);
    end
    check("R9 no error under refresh", 32'(err), 32'd0);

    // R7: long idle, pointer must wrap to keep every row alive
    repeat (6 * ROWS * REF_INT) @(negedge clk);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c += 3) do_read(r, c, "R7 kept after idle");
    check("R7 no error after idle", 32'(err), 32'd0);

    // R6: hold one row open far past the retention limit
    model[3][1] = 8'hC3;
    do_write(3, 1, 8'hC3);
    begin
      logic [DW-1:0] rd; logic rv;
      host_op(3, 1, 1'b0, '0, 300, rd, rv);
      check("R6 held row rvalid", 32'(rv), 32'd1);
      check("R6 held row data", 32'(rd), 32'h000000C3);
    end
    for (int r = 0; r < ROWS; r++)
      if (r != 3) for (int c = 0; c < COLS; c++) model[r][c] = '0;
    repeat (20) @(negedge clk);
    check("R9 err after decay", 32'(err), 32'd1);

    // R8: decayed rows come back as zeros
    do_read(6, 2, "R8 decayed word");
    do_read(0, 0, "R8 decayed word row 0");
    do_read(3, 0, "R8 held row kept");
    for (int i = 0; i < 100; i++) begin
      int r, c;
      r = int'($urandom % ROWS); c = int'($urandom % COLS);
      if ($urandom % 2) do_write(r, c, DW'($urandom));
      else do_read(r, c, "R8 R2 read after decay");
      repeat ($urandom % 30) @(negedge clk);
    end
    check("R9 err sticky", 32'(err), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule